// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records the value of a free-running time counter when a transmit or receive event strobe marks a packet that should carry a timestamp. Each direction has a single 64-bit capture slot. Software reads the slot as two 32-bit words through a small register port. A slot that holds a value is locked: later events in that direction are dropped until software reads the slot's high word, which clears the valid flag and re-arms the slot.

Each direction has an enable bit, and its valid flag can be read back. The receive side also has a message-type filter. It can stamp every receive event, or only those whose message-type code, supplied with the event, equals a code held in a separate match register. A transmit capture raises a cause bit. The interrupt output follows that cause bit gated by its mask bit.

Register offsets (word address): 0 transmit control (bit0 enable, bit1 valid, read-only), 1 receive control (bit0 enable, bit1 valid, read-only, bit2 filter-on), 2 receive match code (bits 3:0), 3 transmit low word, 4 transmit high word, 5 receive low word, 6 receive high word, 7 interrupt (bit0 transmit cause, cleared by writing 1; bit1 mask). Message-type code 0 is Sync and code 1 is Delay_Req.

Top module: `tsu_capture`

## Requirements
- R1: After reset every register reads 0 and `tsIrq` is low.
- R2: An event strobe in a cycle where its direction is enabled and not valid stores the value `timeNow` has in that cycle. The valid flag (bit1 of the control register) is then set. Reading offsets 3/4 (transmit) or 5/6 (receive) returns bits 31:0 and 63:32 of the stored value.
- R3: While a slot is valid, further events in that direction leave the stored value unchanged.
- R4: A read of a slot's high word clears its valid flag, and the next event is captured. A read of the low word leaves the flag set. A high-word read with no valid capture changes nothing.
- R5: While a direction's enable bit is 0 its events are ignored. Writing 0 to the enable bit also clears the direction's valid flag.
- R6: With receive filter-on = 0, every enabled receive event is stamped. With filter-on = 1, only events whose `rxMsgType` equals the match code (bits 3:0 of offset 2) are stamped.
- R7: A transmit capture sets the cause bit (offset 7 bit0). Writing 1 to bit0 clears it. `tsIrq` is high exactly when the cause and mask (bit1) are both 1.
- R8: An event that arrives in the same cycle as the high-word read that unlocks its slot is dropped. The slot ends that cycle not valid and keeps its old value.
- R9: A receive capture does not set the interrupt cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Current time counter value |
| txEvent | input | 1 | Transmit timestamp event strobe |
| rxEvent | input | 1 | Receive timestamp event strobe |
| rxMsgType | input | 4 | Message-type code of the receive event |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (high-word reads have side effects) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the cycle of `regRdEn` |
| tsIrq | output | 1 | Transmit timestamp interrupt |

## Verification
Two functions can land in the same cycle: the high-word read that unlocks a slot, and a new event strobe for that slot. The bench provokes this by asserting `regRdEn` at the transmit high-word offset together with `txEvent` in one cycle. It then expects the control register to show the slot not valid and the low word to still hold the earlier capture. A later lone event must then be captured normally. A second collision, a disabling write in the same phase as a held slot, is judged the same way: the valid flag is cleared and the value is kept.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  // register word offsets
  localparam int TSU_TX_CTRL = 0;
  localparam int TSU_RX_CTRL = 1;
  localparam int TSU_RX_MATCH = 2;
  localparam int TSU_TX_LO = 3;
  localparam int TSU_TX_HI = 4;
  localparam int TSU_RX_LO = 5;
  localparam int TSU_RX_HI = 6;
  localparam int TSU_IRQ = 7;
  localparam int TSU_NUM_DIR = 2;  // index 0 transmit, 1 receive

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic txLoad;
    logic rxLoad;
    logic txValid;
    logic rxValid;
  } tsuCtlT;
endpackage

// File: rtl/tsu_ctrl.sv
module tsu_ctrl
  import tsu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEvent,
  input  logic              rxEvent,
  input  logic [TYPE_W-1:0] rxMsgType,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output tsuCtlT            ctl,
  output logic [DATA_W-1:0] txCtrlWord,
  output logic [DATA_W-1:0] rxCtrlWord,
  output logic [DATA_W-1:0] matchWord,
  output logic [DATA_W-1:0] irqWord,
  output logic              tsIrq
);
  localparam logic [ADDR_W-1:0] aTxCtrl = ADDR_W'(TSU_TX_CTRL);
  localparam logic [ADDR_W-1:0] aRxCtrl = ADDR_W'(TSU_RX_CTRL);
  localparam logic [ADDR_W-1:0] aMatch  = ADDR_W'(TSU_RX_MATCH);
  localparam logic [ADDR_W-1:0] aTxHi   = ADDR_W'(TSU_TX_HI);
  localparam logic [ADDR_W-1:0] aRxHi   = ADDR_W'(TSU_RX_HI);
  localparam logic [ADDR_W-1:0] aIrq    = ADDR_W'(TSU_IRQ);

  logic txEn, rxEn, txValid, rxValid, rxFilterOn, irqCause, irqMask;
  logic [TYPE_W-1:0] rxMatch;
  logic wrTxCtrl, wrRxCtrl, wrMatch, wrIrq, rdTxHi, rdRxHi;
  logic txDisable, rxDisable, rxTypeOk, txFire, rxFire;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;

  assign wrTxCtrl = regWrEn && (regAddr == aTxCtrl);
  assign wrRxCtrl = regWrEn && (regAddr == aRxCtrl);
  assign wrMatch  = regWrEn && (regAddr == aMatch);
  assign wrIrq    = regWrEn && (regAddr == aIrq);
  assign rdTxHi   = regRdEn && (regAddr == aTxHi);
  assign rdRxHi   = regRdEn && (regAddr == aRxHi);

  // a write that clears an enable bit wins over any event in that cycle
  assign txDisable = wrTxCtrl && !regWrData[0];
  assign rxDisable = wrRxCtrl && !regWrData[0];
  assign rxTypeOk  = !rxFilterOn || (rxMsgType == rxMatch);
  assign txFire    = txEn && txEvent && !txValid && !txDisable;
  assign rxFire    = rxEn && rxEvent && !rxValid && !rxDisable && rxTypeOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
      rxFilterOn <= 1'b0;
      rxMatch <= '0;
      irqMask <= 1'b0;
    end else begin
      if (wrTxCtrl) txEn <= regWrData[0];
      if (wrRxCtrl) begin
        rxEn <= regWrData[0];
        rxFilterOn <= regWrData[2];
      end
      if (wrMatch) rxMatch <= regWrData[TYPE_W-1:0];
      if (wrIrq) irqMask <= regWrData[1];
    end
  end

  // slot lock state: set by a capture, released by high read or disable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      rxValid <= 1'b0;
    end else begin
      if (txDisable) txValid <= 1'b0;
      else if (txFire) txValid <= 1'b1;
      else if (rdTxHi) txValid <= 1'b0;
      if (rxDisable) rxValid <= 1'b0;
      else if (rxFire) rxValid <= 1'b1;
      else if (rdRxHi) rxValid <= 1'b0;
    end
  end

  // transmit cause: a new capture takes precedence over a clearing write
  always_ff @(posedge clk) begin
    if (!rstN) irqCause <= 1'b0;
    else if (txFire) irqCause <= 1'b1;
    else if (wrIrq && regWrData[0]) irqCause <= 1'b0;
  end

  assign ctl.txLoad  = txFire;
  assign ctl.rxLoad  = rxFire;
  assign ctl.txValid = txValid;
  assign ctl.rxValid = rxValid;

  assign txCtrlWord = DATA_W'({txValid, txEn});
  assign rxCtrlWord = DATA_W'({rxFilterOn, rxValid, rxEn});
  assign matchWord  = DATA_W'(rxMatch);
  assign irqWord    = DATA_W'({irqMask, irqCause});
  assign tsIrq      = irqCause && irqMask;

  // R4: high-word read releases the lock
  p_hi_read_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdTxHi && txValid) |=> !txValid);
  // R8: event colliding with the unlocking read is dropped
  p_collide_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdTxHi && txValid && txEvent) |=> !txValid);
  // R5: a disabled direction never holds a capture
  p_disabled_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> !rxValid);
  // R7: every new transmit capture leaves the cause bit set
  p_cause_on_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> irqCause);
endmodule

// File: rtl/tsu_datapath.sv
module tsu_datapath
  import tsu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  tsuCtlT              ctl,
  input  logic [2*DATA_W-1:0] timeNow,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   txCtrlWord,
  input  logic [DATA_W-1:0]   rxCtrlWord,
  input  logic [DATA_W-1:0]   matchWord,
  input  logic [DATA_W-1:0]   irqWord,
  output logic [DATA_W-1:0]   regRdData
);
  localparam int TIME_W = 2 * DATA_W;

  logic [TIME_W-1:0] capReg [TSU_NUM_DIR];
  logic [TSU_NUM_DIR-1:0] loadVec, validVec;

  assign loadVec  = {ctl.rxLoad, ctl.txLoad};
  assign validVec = {ctl.rxValid, ctl.txValid};

  for (genvar d = 0; d < TSU_NUM_DIR; d++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) capReg[d] <= '0;
      else if (loadVec[d]) capReg[d] <= timeNow;
    end
    // R3: a held slot keeps its value
    p_hold_value_r3: assert property (@(posedge clk) disable iff (!rstN)
      validVec[d] |=> $stable(capReg[d]));
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (int'(regAddr))
        TSU_TX_CTRL:  regRdData = txCtrlWord;
        TSU_RX_CTRL:  regRdData = rxCtrlWord;
        TSU_RX_MATCH: regRdData = matchWord;
        TSU_TX_LO:    regRdData = capReg[0][DATA_W-1:0];
        TSU_TX_HI:    regRdData = capReg[0][TIME_W-1:DATA_W];
        TSU_RX_LO:    regRdData = capReg[1][DATA_W-1:0];
        TSU_RX_HI:    regRdData = capReg[1][TIME_W-1:DATA_W];
        default:      regRdData = irqWord;
      endcase
    end
  end
endmodule

// File: rtl/tsu_capture.sv
module tsu_capture
  import tsu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int TYPE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*DATA_W-1:0] timeNow,
  input  logic                txEvent,
  input  logic                rxEvent,
  input  logic [TYPE_W-1:0]   rxMsgType,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                tsIrq
);
  tsuCtlT ctl;
  logic [DATA_W-1:0] txCtrlWord, rxCtrlWord, matchWord, irqWord;

  tsu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TYPE_W(TYPE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEvent(txEvent), .rxEvent(rxEvent),
    .rxMsgType(rxMsgType), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .ctl(ctl),
    .txCtrlWord(txCtrlWord), .rxCtrlWord(rxCtrlWord), .matchWord(matchWord),
    .irqWord(irqWord), .tsIrq(tsIrq)
  );

  tsu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .timeNow(timeNow),
    .regRdEn(regRdEn), .regAddr(regAddr), .txCtrlWord(txCtrlWord),
    .rxCtrlWord(rxCtrlWord), .matchWord(matchWord), .irqWord(irqWord),
    .regRdData(regRdData)
  );
endmodule

// File: tb/tsu_capture_tb.sv
module tsu_capture_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] timeNow = '0;
  logic txEvent = 1'b0, rxEvent = 1'b0;
  logic [3:0] rxMsgType = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic tsIrq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tsu_capture u_dut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .txEvent(txEvent),
    .rxEvent(rxEvent), .rxMsgType(rxMsgType), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .tsIrq(tsIrq)
  );

  // {filterOn, matchCode[3:0], msgType[3:0], expectStamp}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 4'd0, 4'd0,  1'b1}, {1'b0, 4'd0, 4'd8,  1'b1},
    {1'b0, 4'd1, 4'd11, 1'b1}, {1'b1, 4'd0, 4'd0,  1'b1},
    {1'b1, 4'd0, 4'd1,  1'b0}, {1'b1, 4'd1, 4'd1,  1'b1},
    {1'b1, 4'd1, 4'd0,  1'b0}, {1'b1, 4'd0, 4'd8,  1'b0}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 3'(a);
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic txPulse(input logic [63:0] t);
    @(negedge clk);
    txEvent = 1'b1; timeNow = t;
    @(negedge clk);
    txEvent = 1'b0; timeNow = ~t;
  endtask

  task automatic rxPulse(input logic [3:0] m, input logic [63:0] t);
    @(negedge clk);
    rxEvent = 1'b1; rxMsgType = m; timeNow = t;
    @(negedge clk);
    rxEvent = 1'b0; timeNow = ~t;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check($sformatf("R1 reg%0d", a), 64'(d), 64'd0);
    end
    check("R1 tsIrq", 64'(tsIrq), 64'd0);

    // R6 / R9 receive filter table
    for (int i = 0; i < 8; i++) begin
      t = 64'h1000_2000_0000_0000 + 64'(i * 97);
      wr(1, {29'd0, VEC[i][9], 2'b01});
      wr(2, {28'd0, VEC[i][8:5]});
      rxPulse(VEC[i][4:1], t);
      rd(1, d);
      check($sformatf("R6 vec%0d valid", i), 64'(d[1]), 64'(VEC[i][0]));
      if (VEC[i][0]) begin
        rd(5, lo); rd(6, hi);
        check($sformatf("R2 rx vec%0d", i), {hi, lo}, t);
      end
      rd(7, d);
      check($sformatf("R9 vec%0d cause", i), 64'(d[0]), 64'd0);
    end

    // R2 / R7 transmit capture with mask on
    wr(0, 32'd1);
    wr(7, 32'd2);
    txPulse(64'hDEAD_BEEF_0123_4567);
    rd(0, d);
    check("R2 tx ctrl", 64'(d), 64'd3);
    check("R7 irq high", 64'(tsIrq), 64'd1);
    // R3 lock
    txPulse(64'h1111_2222_3333_4444);
    rd(3, lo);
    rd(0, d);
    check("R4 lo read keeps valid", 64'(d), 64'd3);
    rd(4, hi);
    check("R3 held value", {hi, lo}, 64'hDEAD_BEEF_0123_4567);
    rd(0, d);
    check("R4 hi read clears valid", 64'(d), 64'd1);
    // R7 clear cause, then capture with mask off
    wr(7, 32'd3);
    check("R7 w1c irq low", 64'(tsIrq), 64'd0);
    rd(7, d);
    check("R7 cause cleared", 64'(d), 64'd2);
    wr(7, 32'd0);
    txPulse(64'h0000_00AB_0000_00CD);
    rd(7, d);
    check("R7 cause set masked", 64'(d), 64'd1);
    check("R7 masked irq low", 64'(tsIrq), 64'd0);
    rd(4, hi);
    check("R4 rearm capture", 64'(hi), 64'h0AB);
    // R4 high read with nothing held
    rd(4, hi);
    rd(0, d);
    check("R4 idle hi read value", 64'(hi), 64'h0AB);
    check("R4 idle hi read ctrl", 64'(d), 64'd1);

    // R8 collision of unlock read and event
    txPulse(64'h0000_0004_0000_0044);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 3'd4; txEvent = 1'b1; timeNow = 64'h0000_0005_0000_0055;
    @(negedge clk);
    regRdEn = 1'b0; txEvent = 1'b0;
    rd(0, d);
    check("R8 valid clear", 64'(d), 64'd1);
    rd(3, lo);
    check("R8 value kept", 64'(lo), 64'h44);
    txPulse(64'h0000_0006_0000_0066);
    rd(3, lo); rd(4, hi);
    check("R8 next capture", {hi, lo}, 64'h0000_0006_0000_0066);

    // R5 disable clears valid and blocks events
    txPulse(64'h0000_0007_0000_0077);
    wr(0, 32'd0);
    rd(0, d);
    check("R5 disable clears", 64'(d), 64'd0);
    txPulse(64'h0000_0008_0000_0088);
    rd(3, lo); rd(0, d);
    check("R5 ignored value", 64'(lo), 64'h77);
    check("R5 ignored ctrl", 64'(d), 64'd0);
    wr(0, 32'd1);
    txPulse(64'h0000_0009_0000_0099);
    rd(3, lo);
    check("R5 reenabled", 64'(lo), 64'h99);
    wr(1, 32'd0);
    rxPulse(4'd0, 64'h5);
    rd(1, d);
    check("R5 rx disabled", 64'(d), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule